// File: doc/BRIEF.md
# Self-Sequencing Three-Channel DMA Ring

This block is a DMA engine whose three channels are wired in a fixed ring, so that it runs a program of control blocks with no processor involved. The first channel plays the part of a program counter: it reads a four-word control block from memory into the configuration registers of the second channel. The second channel then performs the move that the block describes. The third channel steps the program counter on to the next block, and the first channel starts again.

The channel registers share one address space with memory. Any word address whose top bit is set falls in the register window rather than in memory. A move whose destination lies in that window drives the general-purpose output register or overwrites the program counter. A plain copy therefore serves as an output instruction or as a jump. A block whose transfer count is zero stops the ring and raises the halt flag. A start pulse loads the program counter from the base-address input and runs the program again from there.

Top module: `dma_ring_seq`

## Requirements
- R1: After reset, halt_o is 0, out_o is 0 and mem_req_o is 0. A start_i pulse while idle or halted loads the program counter from base_addr_i and begins fetching there. halt_o stays 0 while the program runs.
- R2: A control block is four consecutive words at the program counter: word +0 is the source address, +1 the destination address, +2 the transfer count and +3 the flags. The fetch copies them into the mover's registers before any move begins.
- R3: The mover copies count words. Each word is read from the source and written to the destination in the next cycle. Flags bit 0 set makes the source address advance by one after each word, and clear holds it. Flags bit 1 does the same for the destination.
- R4: When a move completes, the program counter advances by four words, so the next block runs from the following four addresses.
- R5: A block with a transfer count of zero halts the ring. halt_o then stays 1 and no memory access is issued until the next start_i.
- R6: At most one memory access takes place per cycle. Every memory write is issued in the cycle after a memory read.
- R7: Destination addresses with bit 15 set address the register window and issue no memory write. Offset 1 loads out_o. Offset 0 loads the program counter, so the following block is fetched from the written value plus four. Every other offset is ignored.
- R8: A block with count n occupies 10 + 2n cycles. A halting block takes 9 cycles from the start of its fetch until halt_o rises.
- R9: start_i is ignored while the ring is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle or halted |
| base_addr_i | input | 16 | Word address of the first control block |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable, qualified by mem_req_o |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| out_o | output | 32 | General-purpose output register in the register window |
| halt_o | output | 1 | High once a zero-count block has been fetched |

## Verification
The assertions rely on the memory returning read data exactly one cycle after each read request and ignoring requests that are not raised. The bench's memory model keeps to that latency on every access. The assertions also assume that the programs never read through the register window. Every bench program places its sources in plain memory and uses the window only as a destination. The programs include a jump, an ignored register offset and a start pulse in mid-run.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_RD, ST_FETCH_WR, ST_DECODE,
    ST_EXEC_RD, ST_EXEC_WR, ST_ADVANCE, ST_HALT
  } seq_state_e;

  localparam int unsigned CB_WORDS = 4;
  localparam logic [1:0]  CB_SRC   = 2'd0;
  localparam logic [1:0]  CB_DST   = 2'd1;
  localparam logic [1:0]  CB_CNT   = 2'd2;
  localparam logic [1:0]  CB_FLG   = 2'd3;
  localparam int unsigned OFF_PC   = 0;
  localparam int unsigned OFF_OUT  = 1;
endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pc_load_i,
  input  logic [AW-1:0] pc_load_val_i,
  input  logic          pc_adv_i,
  input  logic          cb_we_i,
  input  logic [1:0]    cb_idx_i,
  input  logic          map_we_i,
  input  logic [AW-2:0] map_off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] cnt_o,
  output logic [1:0]    flg_o,
  output logic [DW-1:0] out_o
);
  localparam logic [AW-1:0] PC_STEP = AW'(CB_WORDS);

  logic hit_pc, hit_out;
  assign hit_pc  = map_we_i && (map_off_i == (AW-1)'(OFF_PC));
  assign hit_out = map_we_i && (map_off_i == (AW-1)'(OFF_OUT));

  // program counter (channel 0 address register)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_o <= '0;
    else if (pc_load_i) pc_o <= pc_load_val_i;
    else if (hit_pc)    pc_o <= wdata_i[AW-1:0];
    else if (pc_adv_i)  pc_o <= pc_o + PC_STEP;
  end

  // mover configuration, written only by the fetch channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      cnt_o <= '0;
      flg_o <= '0;
    end else if (cb_we_i) begin
      unique case (cb_idx_i)
        CB_SRC:  src_o <= wdata_i[AW-1:0];
        CB_DST:  dst_o <= wdata_i[AW-1:0];
        CB_CNT:  cnt_o <= wdata_i;
        default: flg_o <= wdata_i[1:0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_o <= '0;
    else if (hit_out) out_o <= wdata_i;
  end
endmodule

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [1:0]    flg_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pc_load_o,
  output logic          pc_adv_o,
  output logic          cb_we_o,
  output logic [1:0]    cb_idx_o,
  output logic          map_we_o,
  output logic [AW-2:0] map_off_o,
  output logic          halt_o
);
  seq_state_e    state_q;
  logic [1:0]    idx_q;
  logic [DW-1:0] rem_q;
  logic [AW-1:0] cur_src_q, cur_dst_q;
  logic          dst_is_reg, start_ok;

  assign dst_is_reg = cur_dst_q[AW-1];
  assign start_ok   = start_i && (state_q == ST_IDLE || state_q == ST_HALT);

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      ST_FETCH_RD: begin mem_req_o = 1'b1; mem_addr_o = pc_i + AW'(idx_q); end
      ST_EXEC_RD:  begin mem_req_o = 1'b1; mem_addr_o = cur_src_q; end
      ST_EXEC_WR:  begin
        mem_req_o  = !dst_is_reg;
        mem_we_o   = !dst_is_reg;
        mem_addr_o = dst_is_reg ? '0 : cur_dst_q;
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = mem_rdata_i;
  assign pc_load_o   = start_ok;
  assign pc_adv_o    = (state_q == ST_ADVANCE);
  assign cb_we_o     = (state_q == ST_FETCH_WR);
  assign cb_idx_o    = idx_q;
  assign map_we_o    = (state_q == ST_EXEC_WR) && dst_is_reg;
  assign map_off_o   = cur_dst_q[AW-2:0];
  assign halt_o      = (state_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      rem_q     <= '0;
      cur_src_q <= '0;
      cur_dst_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HALT: if (start_ok) begin
          state_q <= ST_FETCH_RD;
          idx_q   <= '0;
        end
        ST_FETCH_RD: state_q <= ST_FETCH_WR;
        ST_FETCH_WR: begin
          idx_q   <= idx_q + 2'd1;
          state_q <= (idx_q == CB_FLG) ? ST_DECODE : ST_FETCH_RD;
        end
        ST_DECODE: begin
          rem_q     <= cnt_i;
          cur_src_q <= src_i;
          cur_dst_q <= dst_i;
          state_q   <= (cnt_i == '0) ? ST_HALT : ST_EXEC_RD;
        end
        ST_EXEC_RD: state_q <= ST_EXEC_WR;
        ST_EXEC_WR: begin
          rem_q     <= rem_q - 1'b1;
          cur_src_q <= cur_src_q + AW'(flg_i[0]);
          cur_dst_q <= cur_dst_q + AW'(flg_i[1]);
          state_q   <= (rem_q == DW'(1)) ? ST_ADVANCE : ST_EXEC_RD;
        end
        ST_ADVANCE: begin
          idx_q   <= '0;
          state_q <= ST_FETCH_RD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] out_o,
  output logic          halt_o
);
  logic [AW-1:0] pc, src, dst;
  logic [DW-1:0] cnt;
  logic [1:0]    flg, cb_idx;
  logic          pc_load, pc_adv, cb_we, map_we;
  logic [AW-2:0] map_off;

  dma_ring_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .pc_load_i     (pc_load),
    .pc_load_val_i (base_addr_i),
    .pc_adv_i      (pc_adv),
    .cb_we_i       (cb_we),
    .cb_idx_i      (cb_idx),
    .map_we_i      (map_we),
    .map_off_i     (map_off),
    .wdata_i       (mem_rdata_i),
    .pc_o          (pc),
    .src_o         (src),
    .dst_o         (dst),
    .cnt_o         (cnt),
    .flg_o         (flg),
    .out_o         (out_o)
  );

  dma_ring_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .pc_i        (pc),
    .src_i       (src),
    .dst_i       (dst),
    .cnt_i       (cnt),
    .flg_i       (flg),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .pc_load_o   (pc_load),
    .pc_adv_o    (pc_adv),
    .cb_we_o     (cb_we),
    .cb_idx_o    (cb_idx),
    .map_we_o    (map_we),
    .map_off_o   (map_off),
    .halt_o
  );
endmodule

// File: rtl/dma_ring_seq_chk.sv
module dma_ring_seq_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_i,
  input logic          mem_we_i,
  input logic          addr_hi_i,
  input logic [DW-1:0] out_i,
  input logic          halt_i
);
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i) |-> $past(mem_req_i && !mem_we_i)); // R6
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !mem_req_i); // R5
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !start_i) |=> halt_i); // R5
  AST_NO_MEM_WRITE_TO_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i) |-> !addr_hi_i); // R7
  AST_OUT_NOT_WITH_MEM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_i) |-> !$past(mem_req_i && mem_we_i)); // R7
endmodule

bind dma_ring_seq dma_ring_seq_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mem_req_i (mem_req_o),
  .mem_we_i  (mem_we_o),
  .addr_hi_i (mem_addr_o[AW-1]),
  .out_i     (out_o),
  .halt_i    (halt_o)
);

// File: tb/dma_ring_seq_bench.sv
`timescale 1ns/1ps
module dma_ring_seq_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct packed {
    logic          is_out;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic          mem_req, mem_we, halt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, out;
  logic [DW-1:0] mem [256];
  exp_item_t     exp_q[$];
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  dma_ring_seq u_dma_ring_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .out_o(out), .halt_o(halt)
  );

  // one-cycle read latency memory
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
  end

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA000_0000 | a;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_mem(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back('{is_out: 1'b0, addr: a, data: d});
  endtask

  task automatic push_out(input logic [DW-1:0] d);
    exp_q.push_back('{is_out: 1'b1, addr: '0, data: d});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: memory writes and out_o changes, compared in program order
  initial begin
    logic [DW-1:0] prev_out;
    exp_item_t e;
    prev_out = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && mem_we) begin
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected write", {16'h0, mem_addr}, '0);
        else begin
          e = exp_q.pop_front();
          check(!e.is_out && e.addr == mem_addr && e.data == mem_wdata, "R3 write",
                {mem_addr, mem_wdata[15:0]}, {e.addr, e.data[15:0]});
        end
      end
      if (rst_n && out !== prev_out) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected out", out, prev_out);
        else begin
          e = exp_q.pop_front();
          check(e.is_out && e.data == out, "R7 out", out, e.data);
        end
        prev_out = out;
      end
    end
  end

  // start at base; optionally pulse start again with another base after glitch cycles
  task automatic run_prog(input logic [AW-1:0] b, input int exp_cyc, input int glitch, input string req);
    int n;
    @(negedge clk); base = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; base = 16'h0010;
    check(halt == 1'b0, "R1 running", {31'h0, halt}, 0);
    n = 0;
    while (!halt && n < 1000) begin
      @(posedge clk); n++;
      @(negedge clk);
      start = (n == glitch);
    end
    start = 1'b0;
    check(n == exp_cyc, req, n, exp_cyc);
    check(exp_q.size() == 0, "R2 all expected moves seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    // program A at 0x10
    mem[8'h10] = 32'h40; mem[8'h11] = 32'h50;   mem[8'h12] = 3; mem[8'h13] = 3;
    mem[8'h14] = 32'h44; mem[8'h15] = 32'h60;   mem[8'h16] = 2; mem[8'h17] = 1;
    mem[8'h18] = 32'h46; mem[8'h19] = 32'h8001; mem[8'h1A] = 2; mem[8'h1B] = 1;
    mem[8'h1C] = 0;      mem[8'h1D] = 0;        mem[8'h1E] = 0; mem[8'h1F] = 0;
    // program B at 0x20: jump over 0x24 to 0x30
    mem[8'h20] = 32'h48; mem[8'h21] = 32'h8000; mem[8'h22] = 1; mem[8'h23] = 0;
    mem[8'h24] = 32'h40; mem[8'h25] = 32'h70;   mem[8'h26] = 1; mem[8'h27] = 3;
    mem[8'h48] = 32'h2C;
    mem[8'h30] = 32'h49; mem[8'h31] = 32'h8001; mem[8'h32] = 1; mem[8'h33] = 0;
    mem[8'h34] = 32'h4A; mem[8'h35] = 32'h8003; mem[8'h36] = 1; mem[8'h37] = 0;
    mem[8'h38] = 0;      mem[8'h39] = 0;        mem[8'h3A] = 0; mem[8'h3B] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(halt == 1'b0, "R1 reset halt", {31'h0, halt}, 0);
    check(out == '0, "R1 reset out", out, 0);
    check(mem_req == 1'b0, "R1 reset req", {31'h0, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_req == 1'b0, "R1 idle quiet", {31'h0, mem_req}, 0);

    // A: increment both, increment source only, output register; R3 R4 R8
    push_mem(16'h50, pat(8'h40)); push_mem(16'h51, pat(8'h41)); push_mem(16'h52, pat(8'h42));
    push_mem(16'h60, pat(8'h44)); push_mem(16'h60, pat(8'h45));
    push_out(pat(8'h46)); push_out(pat(8'h47));
    run_prog(16'h0010, 53, -1, "R8 program A cycles");
    check(mem[8'h52] == pat(8'h42), "R3 dst increment", mem[8'h52], pat(8'h42));
    check(mem[8'h60] == pat(8'h45), "R3 dst hold", mem[8'h60], pat(8'h45));
    check(mem[8'h61] == pat(8'h61), "R3 dst hold no spill", mem[8'h61], pat(8'h61));
    check(out == pat(8'h47), "R7 out final", out, pat(8'h47));

    // R5: halted stays halted and quiet
    repeat (5) begin
      @(negedge clk);
      check(halt == 1'b1 && mem_req == 1'b0, "R5 halted quiet", {30'h0, halt, mem_req}, 32'h2);
    end

    // B: jump via pc write, ignored offset, start pulse mid-run (R9)
    push_out(pat(8'h49));
    run_prog(16'h0020, 45, 6, "R9 program B cycles");
    check(mem[8'h70] == pat(8'h70), "R7 jump skipped block", mem[8'h70], pat(8'h70));
    check(out == pat(8'h49), "R7 ignored offset", out, pat(8'h49));

    // C: restart directly on a halting block
    run_prog(16'h001C, 9, -1, "R8 halting block cycles");
    check(halt == 1'b1, "R5 halt on zero count", {31'h0, halt}, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule